// File: doc/BRIEF.md
# Vector Element Address Generator

This block produces the effective address of every element of a vectorised load or store, one address per cycle. A start pulse captures a scalar base, a signed 16-bit immediate, the access size, a 2-bit addressing mode, an indexed-addressing flag, a vector-base flag and the vector length. It then steps an element index from 0 to VL-1. Each address is offered on a valid/ready handshake, and the index moves on only when the handshake completes.

In vector-base and indexed addressing, each address also needs a per-element register value. The block drives the current element index to an external register-read port and takes that port's 64-bit value back in the same cycle. In vector-base addressing that value is the element's base. In indexed addressing it is an index of selectable width, which the block sign-extends. A done pulse follows the last element. A reserved mode raises a one-cycle illegal flag and produces no addresses. All arithmetic wraps modulo 2^64.

Top module: `vec_agen`

## Requirements
- R1: Unit stride (mode_i=0, vec_base_i=0, indexed_i=0): element i has address base + sext(imm) + (1<<size_i)*i, where size_i encodes the access size as 0=1, 1=2, 2=4 or 3=8 bytes.
- R2: Strided (mode_i=1, vec_base_i=0, indexed_i=0): element i has address base + sext(imm)*i. The 16-bit immediate is sign-extended.
- R3: With vec_base_i=1 and indexed_i=0, element i has address elem_data_i + sext(imm)*i, whatever mode_i holds, reserved values included.
- R4: With indexed_i=1, element i has address base + sext(index). The index is the low 8, 16, 32 or 64 bits of elem_data_i for idx_ew_i = 0, 1, 2 or 3. Mode, immediate and vec_base_i are ignored, and the base is always used as a full 64-bit value.
- R5: A start with mode_i of 2 or 3, vec_base_i=0 and indexed_i=0 raises illegal_o for exactly one cycle, in the cycle after the start. It produces no valid address and no done pulse.
- R6: elem_idx_o advances by one only on a cycle with addr_valid_o and addr_ready_i both high. While addr_ready_i is low, the index and the address are held.
- R7: done_o pulses for one cycle in the cycle after the handshake of element VL-1. A legal start with vl_i=0 pulses done_o in the next cycle and produces no addresses.
- R8: addr_valid_o rises in the cycle after an accepted start, with elem_idx_o=0. Operand inputs that change after the start have no effect. A start while addr_valid_o is high is ignored.
- R9: Address arithmetic wraps modulo 2^64.
- R10: After reset, addr_valid_o, done_o and illegal_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse that latches all operands |
| mode_i | input | 2 | 0 unit stride, 1 strided, 2/3 reserved |
| vec_base_i | input | 1 | Base operand is a vector |
| indexed_i | input | 1 | Base-plus-index addressing |
| base_i | input | 64 | Scalar base |
| imm_i | input | 16 | Signed immediate: offset or stride |
| size_i | input | 2 | log2 of the access size in bytes |
| idx_ew_i | input | 2 | Index element width: 8/16/32/64 bits |
| vl_i | input | VL_W | Vector length |
| elem_idx_o | output | VL_W | Element index sent to the register-read port |
| elem_data_i | input | 64 | Register-read result for elem_idx_o, same cycle |
| addr_valid_o | output | 1 | Address valid |
| addr_ready_i | input | 1 | Consumer ready |
| addr_o | output | 64 | Effective address |
| done_o | output | 1 | One-cycle pulse after the last element |
| illegal_o | output | 1 | One-cycle pulse for a reserved mode |

## Verification
The first address is due in the cycle after the start edge. Each later address is due in the cycle after the previous handshake edge. done_o and illegal_o are registered, so each appears one cycle after the edge that caused it. The bench drives its inputs on the falling edge and samples one time unit later, so every sample sees the state left by the rising edge just before it. It counts handshakes to know which element the current address belongs to, and it checks done_o in the sample right after the last handshake.

// File: rtl/vec_agen_pkg.sv
package vec_agen_pkg;
  typedef enum logic [1:0] {
    K_UNIT   = 2'd0,
    K_STRIDE = 2'd1,
    K_VBASE  = 2'd2,
    K_INDEX  = 2'd3
  } agen_kind_e;

  localparam logic [1:0] MODE_UNIT   = 2'd0;
  localparam logic [1:0] MODE_STRIDE = 2'd1;

  function automatic agen_kind_e decode_kind(input logic [1:0] mode, input logic vb, input logic ind);
    if (ind)                     return K_INDEX;
    else if (vb)                 return K_VBASE;
    else if (mode == MODE_UNIT)  return K_UNIT;
    else                         return K_STRIDE;
  endfunction

  function automatic logic is_legal(input logic [1:0] mode, input logic vb, input logic ind);
    return ind || vb || (mode == MODE_UNIT) || (mode == MODE_STRIDE);
  endfunction
endpackage

// File: rtl/vec_agen_ctrl.sv
module vec_agen_ctrl #(
  parameter int VL_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            legal_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            ready_i,
  output logic            busy_o,
  output logic [VL_W-1:0] idx_o,
  output logic            last_o,
  output logic            adv_o,
  output logic            launch_o,
  output logic            done_o,
  output logic            illegal_o
);
  logic            busy_q;
  logic [VL_W-1:0] idx_q, vl_q;
  logic            done_q, illegal_q;
  logic            accept;

  assign accept   = start_i && !busy_q;
  assign launch_o = accept && legal_i && (vl_i != '0);
  assign last_o   = (idx_q == vl_q - VL_W'(1));
  assign adv_o    = busy_q && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      idx_q     <= '0;
      vl_q      <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= (adv_o && last_o) || (accept && legal_i && (vl_i == '0));
      illegal_q <= accept && !legal_i;
      if (launch_o) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        vl_q   <= vl_i;
      end else if (adv_o) begin
        if (last_o) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + VL_W'(1);
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign idx_o     = idx_q;
  assign done_o    = done_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/vec_agen_offset.sv
module vec_agen_offset
  import vec_agen_pkg::*;
#(
  parameter int AW = 64,
  parameter int IW = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  agen_kind_e   kind_i,
  input  logic [IW-1:0] imm_i,
  input  logic [1:0]   size_i,
  input  logic         adv_i,
  output agen_kind_e   kind_o,
  output logic [1:0]   size_o,
  output logic [AW-1:0] off_o
);
  logic [AW-1:0] simm, step_q, off_q;
  agen_kind_e    kind_q;
  logic [1:0]    size_q;

  assign simm = {{(AW-IW){imm_i[IW-1]}}, imm_i};

  // running offset replaces the per-element multiply
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= K_UNIT;
      size_q <= '0;
      step_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      kind_q <= kind_i;
      size_q <= size_i;
      step_q <= (kind_i == K_UNIT) ? (AW'(1) << size_i) : simm;
      off_q  <= (kind_i == K_UNIT) ? simm : '0;
    end else if (adv_i) begin
      off_q <= off_q + step_q;
    end
  end

  assign kind_o = kind_q;
  assign size_o = size_q;
  assign off_o  = off_q;
endmodule

// File: rtl/vec_agen_sext.sv
module vec_agen_sext #(
  parameter int AW = 64
) (
  input  logic [1:0]    ew_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] data_o
);
  localparam int NW = 4;
  logic [AW-1:0] ext [NW];

  for (genvar g = 0; g < NW; g++) begin : g_ew
    localparam int W = (8 << g) > AW ? AW : (8 << g);
    if (W == AW) begin : g_full
      assign ext[g] = data_i;
    end else begin : g_part
      assign ext[g] = {{(AW-W){data_i[W-1]}}, data_i[W-1:0]};
    end
  end

  assign data_o = ext[ew_i];
endmodule

// File: rtl/vec_agen.sv
module vec_agen
  import vec_agen_pkg::*;
#(
  parameter int VL_W = 8,
  parameter int AW   = 64,
  parameter int IW   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      mode_i,
  input  logic            vec_base_i,
  input  logic            indexed_i,
  input  logic [AW-1:0]   base_i,
  input  logic [IW-1:0]   imm_i,
  input  logic [1:0]      size_i,
  input  logic [1:0]      idx_ew_i,
  input  logic [VL_W-1:0] vl_i,
  output logic [VL_W-1:0] elem_idx_o,
  input  logic [AW-1:0]   elem_data_i,
  output logic            addr_valid_o,
  input  logic            addr_ready_i,
  output logic [AW-1:0]   addr_o,
  output logic            done_o,
  output logic            illegal_o
);
  logic          busy, last, adv, launch, legal;
  agen_kind_e    kind_q;
  logic [1:0]    size_q;
  logic [AW-1:0] off, base_q, idx_ext;
  logic [1:0]    ew_q;

  assign legal = is_legal(mode_i, vec_base_i, indexed_i);

  vec_agen_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .legal_i(legal), .vl_i, .ready_i(addr_ready_i),
    .busy_o(busy), .idx_o(elem_idx_o), .last_o(last), .adv_o(adv),
    .launch_o(launch), .done_o, .illegal_o
  );

  vec_agen_offset #(.AW(AW), .IW(IW)) u_off (
    .clk_i, .rst_ni, .load_i(launch),
    .kind_i(decode_kind(mode_i, vec_base_i, indexed_i)),
    .imm_i, .size_i, .adv_i(adv),
    .kind_o(kind_q), .size_o(size_q), .off_o(off)
  );

  vec_agen_sext #(.AW(AW)) u_sext (
    .ew_i(ew_q), .data_i(elem_data_i), .data_o(idx_ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ew_q   <= '0;
    end else if (launch) begin
      base_q <= base_i;
      ew_q   <= idx_ew_i;
    end
  end

  always_comb begin
    unique case (kind_q)
      K_INDEX: addr_o = base_q + idx_ext;
      K_VBASE: addr_o = elem_data_i + off;
      default: addr_o = base_q + off;
    endcase
  end

  assign addr_valid_o = busy;
endmodule

// File: rtl/vec_agen_chk.sv
module vec_agen_chk
  import vec_agen_pkg::*;
#(
  parameter int VL_W = 8,
  parameter int AW   = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [1:0]      mode_i,
  input logic            vec_base_i,
  input logic            indexed_i,
  input logic [VL_W-1:0] vl_i,
  input logic [VL_W-1:0] elem_idx_o,
  input logic            addr_valid_o,
  input logic            addr_ready_i,
  input logic [AW-1:0]   addr_o,
  input logic            done_o,
  input logic            illegal_o,
  input logic            last,
  input agen_kind_e      kind_q,
  input logic [1:0]      size_q
);
  assert_first_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !addr_valid_o && (vl_i != '0) && (indexed_i || vec_base_i || !mode_i[1])
    |=> addr_valid_o && (elem_idx_o == '0));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(elem_idx_o));

  assert_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && addr_ready_i && !last |=> addr_valid_o && (elem_idx_o == $past(elem_idx_o) + VL_W'(1)));

  assert_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && addr_ready_i && last |=> done_o && !addr_valid_o);

  assert_reserved_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !addr_valid_o && mode_i[1] && !vec_base_i && !indexed_i |=> illegal_o && !addr_valid_o);

  assert_illegal_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !addr_valid_o && !done_o);

  assert_unit_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && addr_ready_i && !last && (kind_q == K_UNIT)
    |=> addr_o == $past(addr_o) + (AW'(1) << size_q));
endmodule

bind vec_agen vec_agen_chk #(.VL_W(VL_W), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .start_i, .mode_i, .vec_base_i, .indexed_i, .vl_i,
  .elem_idx_o, .addr_valid_o, .addr_ready_i, .addr_o, .done_o, .illegal_o,
  .last(last), .kind_q(kind_q), .size_q(size_q)
);

// File: tb/vec_agen_test.sv
module vec_agen_test;
  localparam int VL_W = 8;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [1:0]      mode_i = '0;
  logic            vec_base_i = 1'b0;
  logic            indexed_i = 1'b0;
  logic [63:0]     base_i = '0;
  logic [15:0]     imm_i = '0;
  logic [1:0]      size_i = '0;
  logic [1:0]      idx_ew_i = '0;
  logic [VL_W-1:0] vl_i = '0;
  logic [VL_W-1:0] elem_idx_o;
  logic [63:0]     elem_data_i;
  logic            addr_valid_o;
  logic            addr_ready_i = 1'b0;
  logic [63:0]     addr_o;
  logic            done_o, illegal_o;
  logic [63:0]     salt = 64'h0123_4567_89ab_cdef;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [63:0] elem_fn(input logic [VL_W-1:0] i, input logic [63:0] s);
    return s ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  assign elem_data_i = elem_fn(elem_idx_o, salt);

  vec_agen #(.VL_W(VL_W)) uut (
    .clk_i(clk), .rst_ni, .start_i, .mode_i, .vec_base_i, .indexed_i,
    .base_i, .imm_i, .size_i, .idx_ew_i, .vl_i, .elem_idx_o, .elem_data_i,
    .addr_valid_o, .addr_ready_i, .addr_o, .done_o, .illegal_o
  );

  function automatic logic [63:0] ref_ea(input logic [1:0] md, input logic vb, input logic ind,
      input logic [63:0] b, input logic [15:0] im, input logic [1:0] sz, input logic [1:0] ew,
      input logic [63:0] el, input int unsigned i);
    logic [63:0] sim, ii;
    sim = {{48{im[15]}}, im};
    ii  = 64'(i);
    if (ind) begin
      case (ew)
        2'd0: return b + {{56{el[7]}}, el[7:0]};
        2'd1: return b + {{48{el[15]}}, el[15:0]};
        2'd2: return b + {{32{el[31]}}, el[31:0]};
        default: return b + el;
      endcase
    end
    if (vb) return el + sim * ii;
    if (md == 2'd0) return b + sim + (64'd1 << sz) * ii;
    return b + sim * ii;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation; ready_pct = chance of ready per cycle
  task automatic run_op(input logic [1:0] md, input logic vb, input logic ind, input logic [63:0] b,
      input logic [15:0] im, input logic [1:0] sz, input logic [1:0] ew, input int vl,
      input int ready_pct, input bit poke_busy, input string tag);
    bit legal;
    int cnt;
    int guard;
    legal = ind || vb || !md[1];
    @(negedge clk);
    mode_i = md; vec_base_i = vb; indexed_i = ind; base_i = b; imm_i = im;
    size_i = sz; idx_ew_i = ew; vl_i = VL_W'(vl); start_i = 1'b1;
    salt = {$urandom, $urandom};
    @(negedge clk);
    start_i = 1'b0;
    // R8: later operand changes must be ignored
    mode_i = 2'd3; vec_base_i = 1'b0; indexed_i = 1'b0;
    base_i = {$urandom, $urandom}; imm_i = 16'($urandom);
    size_i = 2'($urandom); idx_ew_i = 2'($urandom); vl_i = VL_W'($urandom);
    #1;
    if (!legal) begin
      chk(illegal_o === 1'b1, {"R5 illegal pulse ", tag}, 64'(illegal_o), 64'd1);
      chk(addr_valid_o === 1'b0 && done_o === 1'b0, {"R5 no output ", tag}, 64'(addr_valid_o), 64'd0);
      @(negedge clk); #1;
      chk(illegal_o === 1'b0 && addr_valid_o === 1'b0, {"R5 one cycle ", tag}, 64'(illegal_o), 64'd0);
      return;
    end
    chk(illegal_o === 1'b0, {"R5 no illegal on legal start ", tag}, 64'(illegal_o), 64'd0);
    if (vl == 0) begin
      chk(done_o === 1'b1 && addr_valid_o === 1'b0, {"R7 vl=0 done ", tag}, {62'd0, done_o, addr_valid_o}, 64'd2);
      @(negedge clk); #1;
      chk(done_o === 1'b0 && addr_valid_o === 1'b0, {"R7 vl=0 single pulse ", tag}, 64'(done_o), 64'd0);
      return;
    end
    chk(addr_valid_o === 1'b1 && elem_idx_o == '0, {"R8 first valid ", tag}, 64'(elem_idx_o), 64'd0);
    cnt = 0;
    guard = 0;
    while (cnt < vl && guard < 4000) begin
      addr_ready_i = (int'($urandom_range(99)) < ready_pct);
      if (poke_busy && guard == 0) begin
        start_i = 1'b1; mode_i = 2'd2;
      end
      #1;
      chk(addr_valid_o === 1'b1, {"R6 valid held ", tag}, 64'(addr_valid_o), 64'd1);
      chk(elem_idx_o == VL_W'(cnt), {"R6 index ", tag}, 64'(elem_idx_o), 64'(cnt));
      chk(addr_o === ref_ea(md, vb, ind, b, im, sz, ew, elem_fn(VL_W'(cnt), salt), cnt),
          {ind ? "R4 " : vb ? "R3 " : md == 2'd0 ? "R1 " : "R2 ", "address ", tag},
          addr_o, ref_ea(md, vb, ind, b, im, sz, ew, elem_fn(VL_W'(cnt), salt), cnt));
      chk(done_o === 1'b0, {"R7 no early done ", tag}, 64'(done_o), 64'd0);
      if (addr_ready_i) cnt++;
      @(negedge clk);
      start_i = 1'b0;
      guard++;
    end
    addr_ready_i = 1'b0;
    #1;
    chk(done_o === 1'b1 && addr_valid_o === 1'b0, {"R7 done after last ", tag}, {62'd0, done_o, addr_valid_o}, 64'd2);
    chk(illegal_o === 1'b0, {"R8 start while busy ignored ", tag}, 64'(illegal_o), 64'd0);
    @(negedge clk); #1;
    chk(done_o === 1'b0 && addr_valid_o === 1'b0, {"R7 done single pulse ", tag}, 64'(done_o), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(addr_valid_o === 1'b0 && done_o === 1'b0 && illegal_o === 1'b0, "R10 reset state",
        {61'd0, addr_valid_o, done_o, illegal_o}, 64'd0);
    rst_ni = 1'b1;

    run_op(2'd0, 0, 0, 64'h1000, 16'h0010, 2'd3, 2'd0, 5, 100, 0, "R1 unit 8B");
    run_op(2'd0, 0, 0, 64'h2000, 16'hFFF0, 2'd0, 2'd0, 4, 50, 1, "R1 unit 1B neg imm");
    run_op(2'd1, 0, 0, 64'h8000, 16'hFFF8, 2'd2, 2'd0, 6, 60, 0, "R2 negative stride");
    run_op(2'd3, 1, 0, 64'h0, 16'h0024, 2'd1, 2'd0, 5, 70, 0, "R3 vec base reserved mode");
    run_op(2'd0, 1, 0, 64'h0, 16'h8000, 2'd1, 2'd0, 3, 100, 0, "R3 vec base min imm");
    for (int e = 0; e < 4; e++)
      run_op(2'd2, 1, 1, 64'hFFFF_0000_0000_0000, 16'h7777, 2'd0, 2'(e), 6, 80, 0, "R4 indexed width");
    run_op(2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF8, 16'h0000, 2'd3, 2'd0, 4, 100, 0, "R9 wrap unit");
    run_op(2'd1, 0, 0, 64'h0000_0000_0000_0010, 16'hFFF0, 2'd0, 2'd0, 4, 100, 0, "R9 wrap below zero");
    run_op(2'd2, 0, 0, 64'h1234, 16'h1, 2'd0, 2'd0, 4, 100, 0, "R5 mode 2");
    run_op(2'd3, 0, 0, 64'h1234, 16'h1, 2'd0, 2'd0, 4, 100, 0, "R5 mode 3");
    run_op(2'd1, 0, 0, 64'h1234, 16'h1, 2'd0, 2'd0, 0, 100, 0, "R7 vl zero");
    run_op(2'd0, 0, 0, 64'h4000, 16'h0004, 2'd2, 2'd0, 40, 30, 1, "R6 long stalled");

    for (int n = 0; n < 250; n++)
      run_op(2'($urandom), 1'($urandom_range(3) == 0), 1'($urandom_range(3) == 0),
             {$urandom, $urandom}, 16'($urandom), 2'($urandom), 2'($urandom),
             int'($urandom_range(12)), int'($urandom_range(20, 100)), 1'($urandom), "random");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule